// File: doc/BRIEF.md
# SD/MMC Host Register and Interrupt Front-End

This block is the software-visible face of an SD/MMC host controller. It sits on a simple 32-bit register bus and holds the values that describe the next card command: the argument, the transfer buffer address, and the block size and count. It also holds the four words of the last card response, a view of the card slot, and a sticky interrupt-status register. An enable mask combines the status bits into a single level interrupt.

Software writes a packed command word to start a command. The block splits the word into opcode, response kind, command class and three flags. In the cycle after the write it sends a one-cycle launch strobe to a card-side engine. That engine carries out the command on the card bus. It returns one of three pulses: command-complete, timeout or data-complete. It also returns the 128-bit response and the card-detect and write-protect levels. The block turns these into status bits and captures the response.

Top module: `sdhost_regfront`

## Requirements
- R1: The register map uses byte offsets:
  - interrupt status at 0x00
  - interrupt enable at 0x04
  - buffer address at 0x08
  - command at 0x0C
  - argument at 0x10
  - response words 0 to 3 at 0x14, 0x18, 0x1C and 0x20
  - block length at 0x24
  - block count at 0x28
  - card state at 0x2C

  Argument and buffer address read back exactly as written and appear on their outputs. Any other offset reads zero, and a write to it has no effect.
- R2: The command word has these fields:
  - opcode in bits [5:0]
  - open-drain flag in bit 6
  - response kind in bits [9:8] (0 none, 1 short, 2 long 136-bit, 3 short R3)
  - busy-wait flag in bit 11
  - class in bits [13:12]
  - read-direction flag in bit 15

  An accepted write stores bits [15:0], drives each field on its own output, and raises the launch strobe for exactly the one cycle after the write.
- R3: A command write is accepted only while no command is outstanding. The outstanding flag reads in bit 31 of the card-state register. It is set by an accepted write and cleared by a command-complete or timeout pulse. A write while outstanding changes nothing and gives no strobe.
- R4: Status bit 0 (command complete), bit 1 (data complete) and bit 3 (timeout) are set by their engine pulses. They become visible one cycle after the pulse and stay set until cleared.
- R5: A command-complete pulse together with a timeout pulse sets only bit 3. Bit 0 is left unchanged.
- R6: Writing status clears exactly the bits written as one. A bit whose event arrives in the same cycle as its clear stays set.
- R7: The interrupt output is high exactly when some status bit and its enable bit (same position) are both one. Status bits latch even while disabled.
- R8: On a command-complete pulse without a timeout, the response is captured as follows:
  - Long kind: word k takes response bits [32k+31:32k] for all four words.
  - Kinds 1 and 3: only word 0 is updated.
  - Kind 0: no word changes.
- R9: Block length and block count are 11-bit fields holding the value minus one. Bits above bit 10 are dropped. Each field reads back at its offset and drives its output.
- R10: Card-state bit 0 follows the card-detect input and bit 1 follows the write-protect input. Every change of the card-detect level sets status bit 2 one cycle later.
- R11: After reset, every register reads zero, no command is outstanding, and the interrupt and launch outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, gates read data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt |
| cmd_launch | output | 1 | One-cycle command start strobe |
| cmd_opcode | output | 6 | Command opcode |
| cmd_resp_kind | output | 2 | Expected response kind |
| cmd_class | output | 2 | Command class |
| cmd_open_drain | output | 1 | Open-drain signalling flag |
| cmd_busy_wait | output | 1 | Busy after response flag |
| cmd_read_dir | output | 1 | Data phase reads from card |
| cmd_arg | output | 32 | Command argument |
| xfer_blk_len | output | 11 | Block length minus one |
| xfer_blk_cnt | output | 11 | Block count minus one |
| xfer_buf_addr | output | 32 | Transfer buffer address |
| eng_cmd_done | input | 1 | Command complete pulse |
| eng_cmd_timeout | input | 1 | Command timeout pulse |
| eng_data_done | input | 1 | Data phase complete pulse |
| eng_resp | input | 128 | Response bits from the card |
| card_present | input | 1 | Card detect level |
| card_ro | input | 1 | Write-protect level |

## Verification
A wrong outstanding flag shows up in one of two ways. A second write may produce a second launch strobe. Or bit 31 of the card-state register may stay high after the engine's completion pulse, and the next command is then silently dropped. Both are visible within one cycle of the write or pulse. A wrong status or capture state shows up on the interrupt pin and at the response offsets in the cycle after the engine pulse. The sweep over every response kind and class checks which words moved and which did not. A lost clear or a lost event shows up as a status read that disagrees with the bench's model one cycle after the bus write.

// File: rtl/sdhost_pkg.sv
// Shared constants and field positions for the SD/MMC register front-end.
// Assumes byte addressing with word-aligned registers.
package sdhost_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int OPC_W    = 6;
    localparam int CMD_W    = 16;
    localparam int BLK_W    = 11;
    localparam int STAT_W   = 4;
    localparam int RESP_N   = 4;
    localparam int RESP_W   = DATA_W * RESP_N;

    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_EN    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_BUF   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_ARG   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RESP0 = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_BLEN  = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_BCNT  = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_CARD  = 6'h2C;

    localparam int ST_CMD  = 0;
    localparam int ST_DATA = 1;
    localparam int ST_CARD = 2;
    localparam int ST_TOUT = 3;

    localparam logic [1:0] RK_NONE = 2'd0;
    localparam logic [1:0] RK_LONG = 2'd2;

    typedef struct packed {
        logic             read_dir;
        logic [1:0]       cls;
        logic             busy_wait;
        logic [1:0]       resp_kind;
        logic             open_drain;
        logic [OPC_W-1:0] opcode;
    } cmd_fields_t;

    // Splits a stored command word into its fields
    function automatic cmd_fields_t unpack_cmd(input logic [CMD_W-1:0] w);
        cmd_fields_t f;
        f.opcode     = w[OPC_W-1:0];
        f.open_drain = w[6];
        f.resp_kind  = w[9:8];
        f.busy_wait  = w[11];
        f.cls        = w[13:12];
        f.read_dir   = w[15];
        return f;
    endfunction
endpackage

// File: rtl/sdhost_cmd_ctrl.sv
// Command register, outstanding flag and launch strobe.
// Assumes the engine answers each launch with a done or timeout pulse.
module sdhost_cmd_ctrl
    import sdhost_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic [CMD_W-1:0] wdata,
    input  logic             cmd_done,
    input  logic             cmd_timeout,
    output logic [CMD_W-1:0] cmd_q,
    output logic             busy,
    output logic             launch
);
    // Accept a command only when idle; finish it on done or timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            busy   <= 1'b0;
            launch <= 1'b0;
        end else begin
            launch <= 1'b0;
            if (wr_cmd && !busy) begin
                cmd_q  <= wdata;
                busy   <= 1'b1;
                launch <= 1'b1;
            end else if (busy && (cmd_done || cmd_timeout)) begin
                busy <= 1'b0;
            end
        end
    end

    AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch); // R2
    AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd) |=> ($stable(cmd_q) && !launch)); // R3
    AST_LAUNCH_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> busy); // R3
endmodule

// File: rtl/sdhost_resp_cap.sv
// Four response words captured from the engine on command completion.
// Assumes the command word still holds the response kind at completion.
module sdhost_resp_cap
    import sdhost_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic              cmd_timeout,
    input  logic [1:0]        resp_kind,
    input  logic [RESP_W-1:0] resp_in,
    output logic [RESP_W-1:0] resp_q
);
    logic take;
    assign take = cmd_done && !cmd_timeout && (resp_kind != RK_NONE);

    for (genvar k = 0; k < RESP_N; k++) begin : g_word
        logic cap;
        assign cap = take && ((k == 0) || (resp_kind == RK_LONG));
        // Load this word when its capture condition holds
        always_ff @(posedge clk) begin
            if (!rst_n) resp_q[k*DATA_W +: DATA_W] <= '0;
            else if (cap) resp_q[k*DATA_W +: DATA_W] <= resp_in[k*DATA_W +: DATA_W];
        end
    end

    AST_RESP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && !cmd_timeout) |=> $stable(resp_q)); // R8
    AST_UPPER_LONG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_kind != RK_LONG) |=> $stable(resp_q[RESP_W-1:DATA_W])); // R8
endmodule

// File: rtl/sdhost_irq_ctrl.sv
// Sticky interrupt status with write-one-to-clear, enable mask and
// card-detect change tracking. Assumes event inputs are single-cycle pulses.
module sdhost_irq_ctrl
    import sdhost_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wdata,
    input  logic              cmd_done,
    input  logic              cmd_timeout,
    input  logic              data_done,
    input  logic              card_present,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] enable,
    output logic              irq
);
    logic              present_q;
    logic [STAT_W-1:0] ev_set;
    logic [STAT_W-1:0] clr;

    // Gather this cycle's events; a timeout masks command-complete
    always_comb begin
        ev_set          = '0;
        ev_set[ST_CMD]  = cmd_done && !cmd_timeout;
        ev_set[ST_DATA] = data_done;
        ev_set[ST_CARD] = card_present ^ present_q;
        ev_set[ST_TOUT] = cmd_timeout;
        clr             = wr_stat ? wdata : '0;
    end

    // Update status with set taking priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status    <= '0;
            enable    <= '0;
            present_q <= 1'b0;
        end else begin
            status    <= (status & ~clr) | ev_set;
            present_q <= card_present;
            if (wr_en) enable <= wdata;
        end
    end

    assign irq = |(status & enable);

    AST_TIMEOUT_MASKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_timeout && !status[ST_CMD] && !wr_stat) |=> !status[ST_CMD]); // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(ev_set)) == $past(ev_set))); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((status & $past(status)) == $past(status))); // R4
    AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq); // R7
endmodule

// File: rtl/sdhost_regfront.sv
// Register and interrupt front-end of an SD/MMC host. Decodes bus accesses,
// holds transfer setup registers, and ties the command, response and
// interrupt sub-blocks together. Assumes a single-cycle write strobe and
// a combinational read path sampled by the bus in the same cycle.
module sdhost_regfront
    import sdhost_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              cmd_launch,
    output logic [OPC_W-1:0]  cmd_opcode,
    output logic [1:0]        cmd_resp_kind,
    output logic [1:0]        cmd_class,
    output logic              cmd_open_drain,
    output logic              cmd_busy_wait,
    output logic              cmd_read_dir,
    output logic [DATA_W-1:0] cmd_arg,
    output logic [BLK_W-1:0]  xfer_blk_len,
    output logic [BLK_W-1:0]  xfer_blk_cnt,
    output logic [DATA_W-1:0] xfer_buf_addr,
    input  logic              eng_cmd_done,
    input  logic              eng_cmd_timeout,
    input  logic              eng_data_done,
    input  logic [RESP_W-1:0] eng_resp,
    input  logic              card_present,
    input  logic              card_ro
);
    logic [CMD_W-1:0]  cmd_q;
    logic              busy;
    logic [RESP_W-1:0] resp_q;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] enable;
    cmd_fields_t       fields;

    logic wr_cmd, wr_stat, wr_en;
    assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign wr_en   = bus_wr && (bus_addr == OFS_EN);

    // Plain setup registers written directly from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_arg       <= '0;
            xfer_buf_addr <= '0;
            xfer_blk_len  <= '0;
            xfer_blk_cnt  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_ARG:  cmd_arg       <= bus_wdata;
                OFS_BUF:  xfer_buf_addr <= bus_wdata;
                OFS_BLEN: xfer_blk_len  <= bus_wdata[BLK_W-1:0];
                OFS_BCNT: xfer_blk_cnt  <= bus_wdata[BLK_W-1:0];
                default: ;
            endcase
        end
    end

    sdhost_cmd_ctrl u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(bus_wdata[CMD_W-1:0]),
        .cmd_done(eng_cmd_done), .cmd_timeout(eng_cmd_timeout),
        .cmd_q(cmd_q), .busy(busy), .launch(cmd_launch)
    );

    assign fields         = unpack_cmd(cmd_q);
    assign cmd_opcode     = fields.opcode;
    assign cmd_resp_kind  = fields.resp_kind;
    assign cmd_class      = fields.cls;
    assign cmd_open_drain = fields.open_drain;
    assign cmd_busy_wait  = fields.busy_wait;
    assign cmd_read_dir   = fields.read_dir;

    sdhost_resp_cap u_resp (
        .clk(clk), .rst_n(rst_n), .cmd_done(eng_cmd_done), .cmd_timeout(eng_cmd_timeout),
        .resp_kind(fields.resp_kind), .resp_in(eng_resp), .resp_q(resp_q)
    );

    sdhost_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_en(wr_en),
        .wdata(bus_wdata[STAT_W-1:0]), .cmd_done(eng_cmd_done),
        .cmd_timeout(eng_cmd_timeout), .data_done(eng_data_done),
        .card_present(card_present), .status(status), .enable(enable), .irq(irq)
    );

    // Read multiplexer; unknown offsets and idle cycles return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_STAT:  bus_rdata[STAT_W-1:0] = status;
                OFS_EN:    bus_rdata[STAT_W-1:0] = enable;
                OFS_BUF:   bus_rdata = xfer_buf_addr;
                OFS_CMD:   bus_rdata[CMD_W-1:0] = cmd_q;
                OFS_ARG:   bus_rdata = cmd_arg;
                OFS_BLEN:  bus_rdata[BLK_W-1:0] = xfer_blk_len;
                OFS_BCNT:  bus_rdata[BLK_W-1:0] = xfer_blk_cnt;
                OFS_CARD:  bus_rdata = {busy, 29'd0, card_ro, card_present};
                default: begin
                    for (int k = 0; k < RESP_N; k++)
                        if (bus_addr == OFS_RESP0 + ADDR_W'(4 * k))
                            bus_rdata = resp_q[k*DATA_W +: DATA_W];
                end
            endcase
        end
    end

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (u_irq.status == '0) |-> !irq); // R7
endmodule

// File: tb/sdhost_regfront_tb.sv
module sdhost_regfront_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0, bus_rdata;
    logic         irq, cmd_launch, cmd_open_drain, cmd_busy_wait, cmd_read_dir;
    logic [5:0]   cmd_opcode;
    logic [1:0]   cmd_resp_kind, cmd_class;
    logic [31:0]  cmd_arg, xfer_buf_addr;
    logic [10:0]  xfer_blk_len, xfer_blk_cnt;
    logic         eng_cmd_done = 1'b0, eng_cmd_timeout = 1'b0, eng_data_done = 1'b0;
    logic [127:0] eng_resp = '0;
    logic         card_present = 1'b0, card_ro = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_resp [4];

    always #2 clk = ~clk;

    sdhost_regfront dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata; bus_rd = 1'b0;
    endtask

    task automatic rchk(input logic [5:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic pulse(input bit done, input bit tout, input bit ddone);
        @(negedge clk); eng_cmd_done = done; eng_cmd_timeout = tout; eng_data_done = ddone;
        @(negedge clk); eng_cmd_done = 0; eng_cmd_timeout = 0; eng_data_done = 0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, cw, st;
        for (int k = 0; k < 4; k++) exp_resp[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(irq == 0 && cmd_launch == 0, "R11 outputs", {30'd0, irq, cmd_launch}, 0);
        for (int a = 0; a <= 'h2C; a += 4) rchk(6'(a), 0, "R11 register");

        // R1 readback and undefined offsets
        wr(6'h10, 32'hDEAD_BEEF); wr(6'h08, 32'h1234_5670);
        rchk(6'h10, 32'hDEAD_BEEF, "R1 arg"); rchk(6'h08, 32'h1234_5670, "R1 buf");
        chk(cmd_arg == 32'hDEAD_BEEF && xfer_buf_addr == 32'h1234_5670, "R1 outputs", cmd_arg, 32'hDEAD_BEEF);
        wr(6'h30, 32'hFFFF_FFFF); wr(6'h02, 32'hFFFF_FFFF);
        rchk(6'h30, 0, "R1 undefined"); rchk(6'h02, 0, "R1 undefined");
        rchk(6'h10, 32'hDEAD_BEEF, "R1 undefined write");

        // R9 block fields keep 11 bits
        wr(6'h24, 32'h0000_FFFF); wr(6'h28, 32'h0000_0201);
        rchk(6'h24, 32'h7FF, "R9 length"); rchk(6'h28, 32'h201, "R9 count");
        chk(xfer_blk_len == 11'h7FF && xfer_blk_cnt == 11'h201, "R9 outputs", {xfer_blk_len, 5'd0, xfer_blk_cnt}, {11'h7FF, 5'd0, 11'h201});

        wr(6'h04, 32'hF);
        // R2 R3 R4 R5 R8 sweep over every response kind and class
        for (int i = 0; i < 16; i++) begin
            bit tout;
            logic [1:0] rk, cl;
            logic [5:0] op;
            rk = 2'(i % 4); cl = 2'(i / 4); op = 6'((i * 7 + 1) % 64);
            cw = {16'd0, 1'(i[2] ^ i[3]), 1'b0, cl, 1'(i[1]), 1'b0, rk, 1'b0, 1'(i[0]), op};
            tout = (i % 5 == 0);
            @(negedge clk); bus_addr = 6'h0C; bus_wdata = cw; bus_wr = 1'b1;
            @(negedge clk); bus_wr = 1'b0;
            chk(cmd_launch == 1, "R2 launch", {31'd0, cmd_launch}, 1);
            chk({cmd_read_dir, cmd_class, cmd_busy_wait, cmd_resp_kind, cmd_open_drain, cmd_opcode}
                == {cw[15], cw[13:12], cw[11], cw[9:8], cw[6], cw[5:0]}, "R2 fields",
                {19'd0, cmd_read_dir, cmd_class, cmd_busy_wait, cmd_resp_kind, cmd_open_drain, cmd_opcode},
                {19'd0, cw[15], cw[13:12], cw[11], cw[9:8], cw[6], cw[5:0]});
            rchk(6'h2C, 32'h8000_0000, "R3 busy flag");
            wr(6'h0C, 32'h0000_0FFF);
            chk(cmd_launch == 0, "R3 ignored launch", {31'd0, cmd_launch}, 0);
            rchk(6'h0C, cw, "R3 ignored write");
            for (int k = 0; k < 4; k++) eng_resp[k*32 +: 32] = 32'hA500_0000 | (i << 8) | k;
            pulse(1, tout, 0);
            if (!tout && rk != 0)
                for (int k = 0; k < 4; k++)
                    if (k == 0 || rk == 2) exp_resp[k] = 32'hA500_0000 | (i << 8) | k;
            for (int k = 0; k < 4; k++) rchk(6'(6'h14 + 4 * k), exp_resp[k], "R8 response word");
            st = tout ? 32'h8 : 32'h1;
            rchk(6'h00, st, tout ? "R5 timeout wins" : "R4 done status");
            chk(irq == 1, "R7 irq raised", {31'd0, irq}, 1);
            rchk(6'h2C, 0, "R3 busy cleared");
            wr(6'h00, 32'hF);
            rchk(6'h00, 0, "R6 clear all");
            chk(irq == 0, "R7 irq dropped", {31'd0, irq}, 0);
        end

        // R7 latch while disabled
        wr(6'h04, 0);
        pulse(0, 0, 1);
        rchk(6'h00, 32'h2, "R4 data status");
        chk(irq == 0, "R7 masked", {31'd0, irq}, 0);
        wr(6'h04, 32'h2);
        chk(irq == 1, "R7 unmasked", {31'd0, irq}, 1);

        // R6 partial clear and set-beats-clear
        wr(6'h00, 32'h1);
        rchk(6'h00, 32'h2, "R6 partial clear");
        @(negedge clk); bus_addr = 6'h00; bus_wdata = 32'h2; bus_wr = 1; eng_data_done = 1;
        @(negedge clk); bus_wr = 0; eng_data_done = 0;
        rchk(6'h00, 32'h2, "R6 set wins");
        wr(6'h00, 32'hF);

        // R10 card state and change event
        @(negedge clk); card_present = 1; card_ro = 1;
        @(negedge clk);
        rchk(6'h2C, 32'h3, "R10 card bits");
        rchk(6'h00, 32'h4, "R10 insert change");
        wr(6'h00, 32'h4);
        @(negedge clk); card_present = 0;
        @(negedge clk);
        rchk(6'h00, 32'h4, "R10 removal change");
        rchk(6'h2C, 32'h2, "R10 card bits after removal");

        // R11 reset mid-run
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rchk(6'h10, 0, "R11 arg cleared"); rchk(6'h14, 0, "R11 response cleared");
        chk(irq == 0, "R11 irq", {31'd0, irq}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule